// File: doc/BRIEF.md
# Byte-to-Serial Stream Adapter

This block takes bytes from an upstream byte queue and sends them, one bit at a time, over a single-wire serial link. A controller loads each byte into a right-shifting register. The register's least significant bit is the serial output, so every byte goes out LSB first. The link has a valid/ready handshake. A bit counts as sent only in a cycle where the adapter drives valid and the link drives ready. When ready is low, the adapter holds the current bit.

The queue is show-ahead: while its empty flag is low, the data port carries the head byte. A one-cycle pop strobe removes the head at the next clock edge. The adapter pops the queue when bit 0 of the current byte is accepted, so the following byte is waiting before it is needed. When bit 7 is accepted, the next byte is loaded in the same edge, and the stream continues with no idle cycle between bytes. If the queue is empty at that point, the adapter drops valid and waits for data.

Top module: `byte_serializer`

## Requirements
- R1: A synchronous active-high reset drives valid and pop low and clears the bit position. With the queue empty after reset, valid stays low.
- R2: When the adapter is idle and the queue is not empty, the head byte is loaded at the next edge. In the following cycle valid is high, and the serial output shows bit 0 of that byte.
- R3: The accepted bit stream equals the queue's bytes in order, each byte sent least significant bit first (bit 0 first, bit 7 last).
- R4: In a cycle with valid high and ready low, nothing advances. In the next cycle valid is still high and the serial output bit is unchanged.
- R5: Pop is high exactly in the cycles where bit position 0 of a byte is accepted (valid and ready both high). It lasts one cycle per byte.
- R6: Pop is never high while the queue reports empty.
- R7: When bit position 7 is accepted and the queue is not empty, valid stays high in the next cycle, which carries bit 0 of the next byte.
- R8: When bit position 7 is accepted and the queue is empty, valid is low in the next cycle. Valid is never low partway through a byte.
- R9: The bit position wraps from 7 back to 0 on each reload, so every byte takes exactly eight accepted bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| q_data | input | 8 | Head byte of the queue (show-ahead) |
| q_empty | input | 1 | Queue holds no byte |
| q_pop | output | 1 | One-cycle strobe that removes the queue head |
| ser_bit | output | 1 | Serial data bit |
| ser_valid | output | 1 | Serial bit is valid |
| ser_ready | input | 1 | Link accepts the bit in this cycle |

## Verification
The bit position can go wrong without any visible effect until later. A wrong count shows as a pop strobe at a bit other than the first, or as a byte boundary in the wrong place. That corrupts the first bit of the next byte within eight accepted bits. A wrong shift or load shows in the very next accepted bit, because it no longer matches the queued byte's LSB-first order. A controller stuck in the wrong state shows one cycle after the reload point: valid is high with no data, or an idle gap appears while the queue holds a byte.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic load;
        logic shift;
        logic pop;
    } ctl_cmd_t;

    function automatic int cnt_width(input int w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/bsa_shifter.sv
module bsa_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         sbit
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= din;
        end else if (shift) begin
            sh_q <= {1'b0, sh_q[W-1:1]};
        end
    end

    assign sbit = sh_q[0];

    // R3: right shift brings a zero into the top bit
    a_r3_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (sh_q[W-1] == 1'b0));

endmodule

// File: rtl/bsa_bitcnt.sv
module bsa_bitcnt #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic first,
    output logic last
);
    localparam int CW = bsa_pkg::cnt_width(W);
    localparam logic [CW-1:0] LAST_POS = CW'(W - 1);

    logic [CW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos_q <= '0;
        end else if (inc) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign first = (pos_q == '0);
    assign last  = (pos_q == LAST_POS);

    // R9: a reload at the last position wraps back to the first
    a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
        (last && clr) |=> first);

endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_empty,
    input  logic              ser_ready,
    input  logic              pos_first,
    input  logic              pos_last,
    output bsa_pkg::ctl_cmd_t cmd,
    output logic              valid
);
    import bsa_pkg::*;

    ctl_state_e st_q, st_d;
    logic       acc;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        valid     = (st_q == ST_SEND);
        acc       = valid && ser_ready;
        cmd.load  = ((st_q == ST_IDLE) && !q_empty) || (acc && pos_last && !q_empty);
        cmd.shift = acc && !pos_last;
        cmd.pop   = acc && pos_first && !q_empty;
        st_d      = st_q;
        case (st_q)
            ST_IDLE: if (!q_empty) st_d = ST_SEND;
            ST_SEND: if (acc && pos_last && q_empty) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // R6: no pop toward an empty queue
    a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        cmd.pop |-> !q_empty);

    // R5: pop is a single-cycle pulse tied to an accepted bit
    a_r5_pop_single: assert property (@(posedge clk) disable iff (rst)
        cmd.pop |=> !cmd.pop);

    a_r5_pop_on_accept: assert property (@(posedge clk) disable iff (rst)
        cmd.pop |-> (valid && ser_ready));

endmodule

// File: rtl/byte_serializer.sv
module byte_serializer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] q_data,
    input  logic              q_empty,
    output logic              q_pop,
    output logic              ser_bit,
    output logic              ser_valid,
    input  logic              ser_ready
);
    bsa_pkg::ctl_cmd_t cmd;
    logic pos_first, pos_last;

    bsa_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .q_empty   (q_empty),
        .ser_ready (ser_ready),
        .pos_first (pos_first),
        .pos_last  (pos_last),
        .cmd       (cmd),
        .valid     (ser_valid)
    );

    bsa_bitcnt #(.W(DATA_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cmd.load),
        .inc   (cmd.shift),
        .first (pos_first),
        .last  (pos_last)
    );

    bsa_shifter #(.W(DATA_W)) u_sh (
        .clk   (clk),
        .rst   (rst),
        .load  (cmd.load),
        .shift (cmd.shift),
        .din   (q_data),
        .sbit  (ser_bit)
    );

    assign q_pop = cmd.pop;

    // R4: a stalled bit is held
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_bit)));

    // R7: reload with data waiting leaves no gap
    a_r7_no_gap: assert property (@(posedge clk) disable iff (rst)
        (ser_valid && ser_ready && pos_last && !q_empty) |=> ser_valid);

    // R8: reload with no data drops valid
    a_r8_idle_on_empty: assert property (@(posedge clk) disable iff (rst)
        (ser_valid && ser_ready && pos_last && q_empty) |=> !ser_valid);

endmodule

// File: tb/sim_byte_serializer.sv
`timescale 1ns/1ps
module sim_byte_serializer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] q_data = 8'h00;
    logic       q_empty = 1'b1;
    logic       q_pop;
    logic       ser_bit;
    logic       ser_valid;
    logic       ser_ready = 1'b0;

    always #5 clk = ~clk;

    byte_serializer u0 (
        .clk(clk), .rst(rst), .q_data(q_data), .q_empty(q_empty),
        .q_pop(q_pop), .ser_bit(ser_bit), .ser_valid(ser_valid),
        .ser_ready(ser_ready)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] qmem [0:1023];
    int head = 0, tail = 0, bidx = 0;
    bit pend_pop = 0, resync = 0;
    bit prev_rst = 1, prev_valid = 0, prev_ready = 0, prev_bit = 0;
    bit prev_last_acc = 0, prev_nonempty = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int idx);
        logic [7:0] b;
        b = qmem[(idx >> 3) & 1023];
        return b[idx & 7];
    endfunction

    task automatic step(input bit rv, input int push_pct, input int rdy_pct, input int forced);
        @(posedge clk); #1;
        rst = rv;
        if (pend_pop) head++;
        pend_pop = 0;
        if (forced >= 0 && tail < 1000) begin
            qmem[tail] = 8'(forced); tail++;
        end else if (($urandom % 100) < push_pct && tail < 1000) begin
            qmem[tail] = 8'($urandom); tail++;
        end
        if (rv) resync = 1;
        else if (resync) begin bidx = head * 8; resync = 0; end
        ser_ready = (($urandom % 100) < rdy_pct);
        q_empty   = (head == tail);
        q_data    = q_empty ? 8'($urandom) : qmem[head];
        @(negedge clk);
        pend_pop = q_pop;
        if (rv) begin
            if (prev_rst) begin
                chk(!ser_valid, "R1 valid in reset", int'(ser_valid), 0);
                chk(!q_pop, "R1 pop in reset", int'(q_pop), 0);
            end
        end else begin
            if (!prev_rst) begin
                if (prev_valid && !prev_ready) begin
                    chk(ser_valid, "R4 valid held", int'(ser_valid), 1);
                    chk(ser_bit == prev_bit, "R4 bit held", int'(ser_bit), int'(prev_bit));
                end
                if (prev_last_acc) begin
                    if (prev_nonempty) chk(ser_valid, "R7 no gap", int'(ser_valid), 1);
                    else chk(!ser_valid, "R8 idle on empty", int'(ser_valid), 0);
                end
                if (!prev_valid && prev_nonempty)
                    chk(ser_valid, "R2 load from idle", int'(ser_valid), 1);
            end
            if (ser_valid)
                chk(ser_bit == exp_bit(bidx), "R3/R9 stream bit", int'(ser_bit), int'(exp_bit(bidx)));
            else
                chk((bidx & 7) == 0, "R8 valid low mid-byte", bidx & 7, 0);
            chk(q_pop == (ser_valid && ser_ready && (bidx & 7) == 0), "R5 pop timing",
                int'(q_pop), int'(ser_valid && ser_ready && (bidx & 7) == 0));
            if (q_pop) chk(!q_empty, "R6 pop while empty", int'(q_empty), 0);
        end
        prev_last_acc = !rv && ser_valid && ser_ready && ((bidx & 7) == 7);
        if (!rv && ser_valid && ser_ready) bidx++;
        prev_rst = rv; prev_valid = ser_valid; prev_ready = ser_ready;
        prev_bit = ser_bit; prev_nonempty = !q_empty;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step(1, 0, 0, -1);
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 100, -1);
            chk(!ser_valid, "R1 idle after reset", int'(ser_valid), 0);
        end
        step(0, 0, 100, 8'hA5);
        repeat (14) step(0, 0, 100, -1);
        chk(!ser_valid, "R8 single byte drained", int'(ser_valid), 0);
        step(0, 0, 100, 8'h01);
        step(0, 0, 100, 8'h80);
        repeat (30) step(0, 0, 100, -1);
        repeat (3000) step(0, 8, 70, -1);
        repeat (40) step(0, 100, 100, -1);
        repeat (20) step(0, 0, 0, -1);
        repeat (3) step(1, 0, 50, -1);
        repeat (1500) step(0, 6, 50, -1);
        repeat (400) step(0, 0, 100, -1);
        chk(!ser_valid, "R8 final idle", int'(ser_valid), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule